// File: doc/BRIEF.md
# Four-Context Interleaved DES Engine

This block encrypts or decrypts 64-bit blocks with DES while keeping up to four independent block/key pairs in flight. It holds four round units in series, each followed by a register stage, and the last stage feeds back to the first. A pair entering the ring makes four trips around it, one round per stage per cycle, and leaves after sixteen rounds through a single final permutation. The input permutations and the entry multiplexer exist only once and are shared by all contexts.

Every pair carries its own key and its own direction flag, so the key may change on every block with no lost cycles. A new pair is taken only when the first stage's slot is not claimed by a context coming back around. That is true whenever the context arriving from the last stage has just finished. Results leave in the order the pairs were accepted.

Top module: `des_ring4`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are low. After reset is released, `in_ready` is high and `out_valid` stays low until a pair accepted after reset has completed.
- R2: With `in_dec` = 0, the result is the DES encryption of `in_text` under `in_key`. Bit 63 of each bus is DES bit 1, the first bit of the standard numbering.
- R3: With `in_dec` = 1, the result is the DES decryption. Decrypting a ciphertext with the key that produced it returns the original plaintext.
- R4: A pair accepted at a rising edge (`in_valid` and `in_ready` high before that edge) produces `out_valid` exactly 15 rising edges later, which is 16 cycles counting the accepting cycle. `out_valid` lasts one cycle per block.
- R5: Results leave in the order in which their pairs were accepted.
- R6: Four pairs can be in flight at once. While four contexts occupy the ring and none is finishing, `in_ready` is low.
- R7: In a cycle in which a block leaves, `in_ready` is high, so a new pair can take the freed slot at that same edge. Four pairs offered back to back are followed by a fifth that is accepted 16 edges after the first.
- R8: Key and direction are taken per pair. Interleaved encryptions and decryptions with different keys each return their own correct result.
- R9: The least significant bit of each key byte (bits 56, 48, 40, 32, 24, 16, 8, 0 of `in_key`) has no effect on the result.
- R10: A pair presented while `in_ready` is low is not taken and yields no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | First ring slot is free this cycle |
| in_dec | input | 1 | 1 = decrypt, 0 = encrypt |
| in_text | input | 64 | Input block, bit 63 is DES bit 1 |
| in_key | input | 64 | Key with parity bits, bit 63 is DES bit 1 |
| out_valid | output | 1 | Result valid, one cycle per block |
| out_text | output | 64 | Result block |

## Verification
Known-answer vectors check the round function, the S-boxes, the permutations and both key schedules. A wrong shift table or a wrong decrypt rotation produces garbage or fails to round-trip. Four pairs are streamed back to back and then a fifth is offered. A ring that mis-counts trips changes the 16-cycle latency or reorders results. A ring that lets a new pair overwrite a returning context loses a block or accepts the fifth too early. A pair is held at the input while the ring is full, and mixed-direction traffic with changing keys exposes any direction or key state that leaks between contexts. Flipped parity bits would change the result if the key selection read the wrong bits.

// File: rtl/des_ring4.sv
module des_ring4 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_dec,
  input  logic [63:0] in_text,
  input  logic [63:0] in_key,
  output logic        out_valid,
  output logic [63:0] out_text
);

  localparam int NS = 4;

  localparam int IP_T [64] = '{
    58, 50, 42, 34, 26, 18, 10, 2, 60, 52, 44, 36, 28, 20, 12, 4,
    62, 54, 46, 38, 30, 22, 14, 6, 64, 56, 48, 40, 32, 24, 16, 8,
    57, 49, 41, 33, 25, 17,  9, 1, 59, 51, 43, 35, 27, 19, 11, 3,
    61, 53, 45, 37, 29, 21, 13, 5, 63, 55, 47, 39, 31, 23, 15, 7};

  localparam int FP_T [64] = '{
    40, 8, 48, 16, 56, 24, 64, 32, 39, 7, 47, 15, 55, 23, 63, 31,
    38, 6, 46, 14, 54, 22, 62, 30, 37, 5, 45, 13, 53, 21, 61, 29,
    36, 4, 44, 12, 52, 20, 60, 28, 35, 3, 43, 11, 51, 19, 59, 27,
    34, 2, 42, 10, 50, 18, 58, 26, 33, 1, 41,  9, 49, 17, 57, 25};

  localparam int E_T [48] = '{
    32,  1,  2,  3,  4,  5,  4,  5,  6,  7,  8,  9,
     8,  9, 10, 11, 12, 13, 12, 13, 14, 15, 16, 17,
    16, 17, 18, 19, 20, 21, 20, 21, 22, 23, 24, 25,
    24, 25, 26, 27, 28, 29, 28, 29, 30, 31, 32,  1};

  localparam int P_T [32] = '{
    16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

  localparam int PC1_T [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  localparam int PC2_T [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  localparam logic [255:0] SBOX [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  function automatic logic [27:0] key_rot(input logic [27:0] x, input logic dec, input logic [3:0] n);
    logic single;
    single = (n == 4'd1) || (n == 4'd8) || (n == 4'd15);
    if (!dec) return (single || n == 4'd0) ? {x[26:0], x[27]} : {x[25:0], x[27:26]};
    if (n == 4'd0) return x;
    return single ? {x[0], x[27:1]} : {x[1:0], x[27:2]};
  endfunction

  logic [31:0] s_l [NS];
  logic [31:0] s_r [NS];
  logic [27:0] s_c [NS];
  logic [27:0] s_d [NS];
  logic [1:0]  s_pass [NS];
  logic [NS-1:0] s_dec;
  logic [NS-1:0] s_v;

  logic [31:0] nx_l [NS];
  logic [31:0] nx_r [NS];
  logic [27:0] nx_c [NS];
  logic [27:0] nx_d [NS];
  logic [1:0]  nx_pass [NS];
  logic [NS-1:0] nx_dec;

  logic [63:0] ip_o;
  logic [55:0] pc1_o;
  logic [63:0] pre_fp;
  logic        loop_back;
  logic        accept;

  assign loop_back = s_v[NS-1] && (s_pass[NS-1] != 2'd3);
  assign out_valid = s_v[NS-1] && (s_pass[NS-1] == 2'd3);
  assign in_ready  = rst_n && !loop_back;
  assign accept    = in_valid && in_ready;

  for (genvar i = 0; i < 64; i++) begin : g_ip
    assign ip_o[63-i] = in_text[64-IP_T[i]];
  end
  for (genvar i = 0; i < 56; i++) begin : g_pc1
    assign pc1_o[55-i] = in_key[64-PC1_T[i]];
  end

  assign pre_fp = {s_r[NS-1], s_l[NS-1]};
  for (genvar i = 0; i < 64; i++) begin : g_fp
    assign out_text[63-i] = pre_fp[64-FP_T[i]];
  end

  for (genvar k = 0; k < NS; k++) begin : g_rnd
    logic [31:0] ul, ur;
    logic [27:0] uc, ud, cn, dn;
    logic [1:0]  upass;
    logic        udec;
    logic [3:0]  rn;
    logic [55:0] cd;
    logic [47:0] sk, ex, mx;
    logic [31:0] so, fo;

    if (k == 0) begin : g_mux
      assign ul    = loop_back ? s_l[NS-1] : ip_o[63:32];
      assign ur    = loop_back ? s_r[NS-1] : ip_o[31:0];
      assign uc    = loop_back ? s_c[NS-1] : pc1_o[55:28];
      assign ud    = loop_back ? s_d[NS-1] : pc1_o[27:0];
      assign udec  = loop_back ? s_dec[NS-1] : in_dec;
      assign upass = loop_back ? s_pass[NS-1] + 2'd1 : 2'd0;
    end else begin : g_chain
      assign ul    = s_l[k-1];
      assign ur    = s_r[k-1];
      assign uc    = s_c[k-1];
      assign ud    = s_d[k-1];
      assign udec  = s_dec[k-1];
      assign upass = s_pass[k-1];
    end

    assign rn = {upass, 2'(k)};
    assign cn = key_rot(uc, udec, rn);
    assign dn = key_rot(ud, udec, rn);
    assign cd = {cn, dn};

    for (genvar i = 0; i < 48; i++) begin : g_pc2
      assign sk[47-i] = cd[56-PC2_T[i]];
      assign ex[47-i] = ur[32-E_T[i]];
    end
    assign mx = ex ^ sk;

    for (genvar j = 0; j < 8; j++) begin : g_sb
      logic [5:0] b;
      logic [5:0] idx;
      assign b   = mx[47-6*j -: 6];
      assign idx = {b[5], b[0], b[4:1]};
      assign so[31-4*j -: 4] = SBOX[j][255 - 4*int'(idx) -: 4];
    end

    for (genvar i = 0; i < 32; i++) begin : g_p
      assign fo[31-i] = so[32-P_T[i]];
    end

    assign nx_l[k]    = ur;
    assign nx_r[k]    = ul ^ fo;
    assign nx_c[k]    = cn;
    assign nx_d[k]    = dn;
    assign nx_pass[k] = upass;
    assign nx_dec[k]  = udec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_v <= '0;
    else        s_v <= {s_v[NS-2:0], loop_back || accept};
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NS; k++) begin
      s_l[k]    <= nx_l[k];
      s_r[k]    <= nx_r[k];
      s_c[k]    <= nx_c[k];
      s_d[k]    <= nx_d[k];
      s_pass[k] <= nx_pass[k];
    end
    s_dec <= nx_dec;
  end

  // R4: a result appears exactly 16 sampled cycles after its acceptance
  assert_result_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept, 16) |-> out_valid);

  // R4 and R5: no result without a matching acceptance 16 cycles back
  assert_no_orphan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept, 16));

  // R7: an accepted pair occupies the first stage on its first pass
  assert_enter_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (s_v[0] && s_pass[0] == 2'd0));

  // R6: a full ring with nothing leaving refuses new input
  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&s_v && !out_valid) |-> !in_ready);

endmodule

// File: tb/des_ring4_tb_top.sv
module des_ring4_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dec = 1'b0;
  logic [63:0] in_text = '0;
  logic [63:0] in_key = '0;
  logic        out_valid;
  logic [63:0] out_text;

  always #10 clk = ~clk;

  des_ring4 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dec(in_dec), .in_text(in_text), .in_key(in_key),
    .out_valid(out_valid), .out_text(out_text));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nbad = 0;
  int nin = 0;
  int nout = 0;
  logic [63:0] exp_d [64];
  int          acc_c [64];
  logic [63:0] got_d [64];
  int          got_c [64];

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (nout < 64) begin
        got_d[nout] = out_text;
        got_c[nout] = cyc;
      end
      nout++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nin = 0;
    nout = 0;
  endtask

  task automatic push(input logic [63:0] d, input logic [63:0] k, input bit dec, input logic [63:0] e);
    @(negedge clk);
    in_valid = 1'b1;
    in_text  = d;
    in_key   = k;
    in_dec   = dec;
    while (!in_ready) @(negedge clk);
    acc_c[nin] = cyc + 1;
    exp_d[nin] = e;
    nin++;
  endtask

  task automatic stop_push();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  task automatic verify(input string req);
    chk(nout == nin, {req, " count/R4"}, 64'(nout), 64'(nin));
    for (int i = 0; i < nin && i < nout; i++) begin
      chk(got_d[i] === exp_d[i], req, got_d[i], exp_d[i]);
      chk(got_c[i] == acc_c[i] + 15, "R4 latency", 64'(got_c[i]), 64'(acc_c[i] + 15));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b0, "R1 ready in reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_encrypt();
    clear_log();
    push(64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 1'b0, 64'h85E813540F0AB405);
    push(64'h8787878787878787, 64'h0E329232EA6D0D73, 1'b0, 64'h0000000000000000);
    push(64'h0000000000000000, 64'h0000000000000000, 1'b0, 64'h8CA64DE9C1B123A7);
    push(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1'b0, 64'h7359B2163E4EDC58);
    stop_push();
    drain();
    verify("R2 encrypt");
  endtask

  task automatic t_decrypt();
    clear_log();
    push(64'h85E813540F0AB405, 64'h133457799BBCDFF1, 1'b1, 64'h0123456789ABCDEF);
    stop_push();
    repeat (5) @(negedge clk);
    push(64'h0000000000000000, 64'h0E329232EA6D0D73, 1'b1, 64'h8787878787878787);
    push(64'h8CA64DE9C1B123A7, 64'h0000000000000000, 1'b1, 64'h0000000000000000);
    stop_push();
    drain();
    verify("R3 decrypt");
  endtask

  task automatic t_roundtrip();
    logic [63:0] ct;
    clear_log();
    push(64'h5AC3_19E7_0B44_D2F6, 64'hA1B2C3D4E5F60718, 1'b0, 64'h0);
    stop_push();
    drain();
    chk(nout == 1, "R3 roundtrip first pass", 64'(nout), 64'd1);
    ct = got_d[0];
    clear_log();
    push(ct, 64'hA1B2C3D4E5F60718, 1'b1, 64'h5AC3_19E7_0B44_D2F6);
    stop_push();
    drain();
    verify("R3 roundtrip");
  endtask

  task automatic t_mixed();
    clear_log();
    push(64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 1'b0, 64'h85E813540F0AB405);
    push(64'h0000000000000000, 64'h0E329232EA6D0D73, 1'b1, 64'h8787878787878787);
    push(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1'b0, 64'h7359B2163E4EDC58);
    push(64'h8CA64DE9C1B123A7, 64'h0000000000000000, 1'b1, 64'h0000000000000000);
    push(64'h8787878787878787, 64'h0E329232EA6D0D73, 1'b0, 64'h0000000000000000);
    push(64'h85E813540F0AB405, 64'h133457799BBCDFF1, 1'b1, 64'h0123456789ABCDEF);
    stop_push();
    drain();
    verify("R8 R5 mixed");
    chk(acc_c[4] == acc_c[0] + 16, "R7 slot reuse", 64'(acc_c[4]), 64'(acc_c[0] + 16));
    chk(acc_c[5] == acc_c[1] + 16, "R7 slot reuse second", 64'(acc_c[5]), 64'(acc_c[1] + 16));
  endtask

  task automatic t_full();
    clear_log();
    push(64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 1'b0, 64'h85E813540F0AB405);
    push(64'h8787878787878787, 64'h0E329232EA6D0D73, 1'b0, 64'h0000000000000000);
    push(64'h0000000000000000, 64'h0000000000000000, 1'b0, 64'h8CA64DE9C1B123A7);
    push(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1'b0, 64'h7359B2163E4EDC58);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_text = 64'hDEADBEEF00000000 + 64'(i);
      in_key  = 64'h1122334455667788;
      chk(in_ready == 1'b0, "R6 full ring", 64'(in_ready), 64'd0);
    end
    in_valid = 1'b0;
    drain();
    verify("R10 held offer ignored");
  endtask

  task automatic t_parity();
    clear_log();
    push(64'h0123456789ABCDEF, 64'h123556789ABDDEF0, 1'b0, 64'h85E813540F0AB405);
    push(64'h8787878787878787, 64'h0F339333EB6C0C72, 1'b0, 64'h0000000000000000);
    stop_push();
    drain();
    verify("R9 parity bits");
  endtask

  bit finished = 1'b0;

  initial begin
    #3_000_000;
    if (!finished) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_encrypt();
    t_decrypt();
    t_roundtrip();
    t_mixed();
    t_full();
    t_parity();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule